// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers a configurable number of interrupt request lines, records each one in a status register, and masks the recorded requests with a per-input enable register. It then drives a single request line towards a processor. Each input is built as either an edge-detecting or a level-following cell. The choice is made per input through a parameter bit mask. Priority is fixed by position: the input with the smallest index wins.

Software reaches the controller through a single-cycle register port. Writes take effect at the clock edge, and reads return combinationally from the address. Through this port software can:
- read the recorded and the pending requests,
- acknowledge edge and level requests by writing ones,
- raise requests from software,
- read a vector register that holds the index of the winning pending input.

A two-bit control register holds two settings. The first bit gates the output request. The second bit selects whether status is fed by the hardware input lines or by software set writes.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the status, enable and control registers read zero, `irq_out` is low and the vector register reads all ones (BUS_W bits).
- R2: Register offsets on `reg_addr` are as follows:
  - 0 reads status (read-only).
  - 1 reads pending (read-only).
  - 2 is the enable register (read/write).
  - 3 is acknowledge (write ones to clear, reads zero).
  - 4 is software set (write ones to set, reads zero).
  - 5 is control (read/write, bit 0 = output enable, bit 1 = hardware select).
  - 6 reads the vector.
  
  Writes to read-only offsets change nothing, and bits at or above NUM_SRC read zero.
- R3: An edge input with hardware select at 1 sets its status bit when it is sampled 0 on one rising clock edge and 1 on the next. The bit is then visible after that second edge. It stays set until a 1 is written to its acknowledge bit, and that write clears it even while the input is still high.
- R4: A level input with hardware select at 1 sets its status bit at every edge where it is high. An acknowledge write cannot clear the bit while the input is high. Once the input is low, the bit stays set until it is acknowledged.
- R5: Software set writes take effect only while hardware select is 0. Hardware input lines affect status only while hardware select is 1.
- R6: The pending register equals status AND enable. `irq_out` is high exactly when output enable is 1 and any pending bit is set.
- R7: The vector register returns the smallest index whose pending bit is set, or all ones when no bit is pending.
- R8: A set and an acknowledge of the same status bit in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | NUM_SRC | Interrupt request lines |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for `reg_addr` |
| irq_out | output | 1 | Request to the processor |

## Verification
Several properties are checked on every cycle:
- status bits rise only when an allowed set cause was present one cycle earlier;
- a high level input always keeps its status set;
- the output request never rises while output enable is low;
- the vector always names a pending bit that has no pending bit below it.

Other behaviour can only be shown by the bench's scenarios. This covers the register values across every status pattern against several masks, and the distinction between sticky edge status and level status after acknowledge. It also covers which of the two request sources is ignored under each hardware-select setting, and a set and an acknowledge of the same bit meeting in one cycle.

// File: rtl/irq_ctrl_pkg.sv
// Shared definitions for the prioritized interrupt controller.
// Assumes a 3-bit register offset space and a two-bit control register.
package irq_ctrl_pkg;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_STATUS  = 3'd0,
        RA_PENDING = 3'd1,
        RA_ENABLE  = 3'd2,
        RA_ACK     = 3'd3,
        RA_SWSET   = 3'd4,
        RA_CTRL    = 3'd5,
        RA_VECTOR  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic hw_sel;
        logic out_en;
    } ctrl_t;
endpackage

// File: rtl/irq_src_cell.sv
// One interrupt source: detects a rising edge or follows a level and keeps
// a status flop. Assumes ack and sw_set are single-cycle write pulses.
module irq_src_cell #(
    parameter bit IS_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_in,
    input  logic hw_sel,
    input  logic sw_set,
    input  logic ack,
    output logic stat_q
);
    logic hw_hit;
    logic set_now;
    logic prev_q;

    // Previous sample of the input, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_in;
    end

    // Pick the hardware trigger form for this cell.
    generate
        if (IS_EDGE) begin : g_edge
            assign hw_hit = src_in & ~prev_q;
        end else begin : g_level
            assign hw_hit = src_in;
        end
    endgenerate

    // Select the set source from the hardware-select control.
    always_comb set_now = hw_sel ? hw_hit : sw_set;

    // Status flop: set wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= 1'b0;
        else if (set_now) stat_q <= 1'b1;
        else if (ack)     stat_q <= 1'b0;
    end

    assert_stat_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> $past((hw_sel && src_in) || (!hw_sel && sw_set)));

    generate
        if (!IS_EDGE) begin : g_level_chk
            assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_sel && src_in) |=> stat_q);
        end
    endgenerate
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder: smallest set index wins; all ones when none set.
// Assumes OUT_W is wide enough to hold WIDTH-1.
module irq_prio_enc #(
    parameter int WIDTH = 16,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req,
    output logic             any,
    output logic [OUT_W-1:0] idx
);
    // Scan from the top so the lowest set index is the last one written.
    always_comb begin
        idx = '1;
        any = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = OUT_W'(i);
                any = 1'b1;
            end
        end
    end

    assert_vec_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx[$clog2(WIDTH+1)-1:0]] &&
                 ((req & ((WIDTH'(1) << idx[$clog2(WIDTH+1)-1:0]) - WIDTH'(1))) == '0)));
    assert_vec_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (idx == '1));
endmodule

// File: rtl/irq_reg_port.sv
// Register port: holds the enable and control registers, decodes write
// pulses for acknowledge and software set, and returns read data.
// Assumes at most one access per cycle and NUM_SRC <= BUS_W.
module irq_reg_port
    import irq_ctrl_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int NUM_SRC = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [BUS_W-1:0]      reg_wdata,
    input  logic [NUM_SRC-1:0]    stat_vec,
    input  logic [NUM_SRC-1:0]    pend_vec,
    input  logic [BUS_W-1:0]      vec_idx,
    output logic [NUM_SRC-1:0]    en_q,
    output ctrl_t                 ctrl_q,
    output logic [NUM_SRC-1:0]    ack_pulse,
    output logic [NUM_SRC-1:0]    set_pulse,
    output logic [BUS_W-1:0]      reg_rdata
);
    reg_addr_e addr_e;
    logic [BUS_W-1:0] stat_wide;
    logic [BUS_W-1:0] pend_wide;
    logic [BUS_W-1:0] en_wide;
    logic [BUS_W-1:0] ctrl_wide;

    assign addr_e = reg_addr_e'(reg_addr);

    // Enable and control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            ctrl_q <= '0;
        end else if (reg_wr) begin
            if (addr_e == RA_ENABLE) en_q   <= reg_wdata[NUM_SRC-1:0];
            if (addr_e == RA_CTRL)   ctrl_q <= ctrl_t'(reg_wdata[1:0]);
        end
    end

    // One-cycle acknowledge and software-set pulses.
    always_comb begin
        ack_pulse = (reg_wr && addr_e == RA_ACK)   ? reg_wdata[NUM_SRC-1:0] : '0;
        set_pulse = (reg_wr && addr_e == RA_SWSET) ? reg_wdata[NUM_SRC-1:0] : '0;
    end

    // Zero-extend source-wide vectors to the bus width.
    always_comb begin
        stat_wide = '0;
        pend_wide = '0;
        en_wide   = '0;
        ctrl_wide = '0;
        stat_wide[NUM_SRC-1:0] = stat_vec;
        pend_wide[NUM_SRC-1:0] = pend_vec;
        en_wide[NUM_SRC-1:0]   = en_q;
        ctrl_wide[1:0]         = ctrl_q;
    end

    // Read multiplexer.
    always_comb begin
        case (addr_e)
            RA_STATUS:  reg_rdata = stat_wide;
            RA_PENDING: reg_rdata = pend_wide;
            RA_ENABLE:  reg_rdata = en_wide;
            RA_CTRL:    reg_rdata = ctrl_wide;
            RA_VECTOR:  reg_rdata = vec_idx;
            default:    reg_rdata = '0;
        endcase
    end

    assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2) |=> (en_q == $past(reg_wdata[NUM_SRC-1:0])));
    assert_enable_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 3'd2) |=> $stable(en_q));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the prioritized interrupt controller. EDGE_SEL bit i set makes
// input i edge sensitive, clear makes it level sensitive.
// Assumes NUM_SRC <= BUS_W and BUS_W is 8, 16 or 32.
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int             BUS_W    = 32,
    parameter int             NUM_SRC  = 16,
    parameter logic [BUS_W-1:0] EDGE_SEL = 32'h0000_00FF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    irq_src,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [BUS_W-1:0]      reg_wdata,
    output logic [BUS_W-1:0]      reg_rdata,
    output logic                  irq_out
);
    logic [NUM_SRC-1:0] stat_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] ack_pulse;
    logic [NUM_SRC-1:0] set_pulse;
    logic [BUS_W-1:0]   vec_idx;
    logic               any_pend;
    ctrl_t              ctrl_q;

    irq_reg_port #(.BUS_W(BUS_W), .NUM_SRC(NUM_SRC)) u_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .stat_vec(stat_vec), .pend_vec(pend_vec),
        .vec_idx(vec_idx), .en_q(en_q), .ctrl_q(ctrl_q),
        .ack_pulse(ack_pulse), .set_pulse(set_pulse), .reg_rdata(reg_rdata)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            irq_src_cell #(.IS_EDGE(EDGE_SEL[i])) u_cell (
                .clk(clk), .rst_n(rst_n), .src_in(irq_src[i]),
                .hw_sel(ctrl_q.hw_sel), .sw_set(set_pulse[i]),
                .ack(ack_pulse[i]), .stat_q(stat_vec[i])
            );
        end
    endgenerate

    // Pending requests are the recorded ones that are enabled.
    always_comb pend_vec = stat_vec & en_q;

    irq_prio_enc #(.WIDTH(NUM_SRC), .OUT_W(BUS_W)) u_enc (
        .clk(clk), .rst_n(rst_n), .req(pend_vec), .any(any_pend), .idx(vec_idx)
    );

    // Output request gated by the output-enable control bit.
    always_comb irq_out = ctrl_q.out_en & any_pend;

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.out_en |-> !irq_out);
    assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((stat_vec & en_q) != '0));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
// Bench: 8 inputs on an 8-bit bus, inputs 0-3 edge, 4-7 level.
module sim_irq_prio_ctrl;
    localparam int BW = 8;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_src = '0;
    logic [2:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [BW-1:0] reg_wdata = '0;
    logic [BW-1:0] reg_rdata;
    logic          irq_out;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    irq_prio_ctrl #(.BUS_W(BW), .NUM_SRC(NS), .EDGE_SEL(8'h0F)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    function automatic logic [7:0] lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 8'(i);
        return 8'hFF;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] p, m;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset values
        chk_reg("R1 status", 3'd0, 8'h00);
        chk_reg("R1 enable", 3'd2, 8'h00);
        chk_reg("R1 ctrl",   3'd5, 8'h00);
        chk_reg("R1 vector", 3'd6, 8'hFF);
        chk("R1 irq", {7'b0, irq_out}, 8'h00);

        // R2/R5/R6/R7: sweep all status patterns against several masks
        wr(3'd5, 8'h01);                       // output on, software source
        for (int pi = 0; pi < 256; pi++) begin
            for (int k = 0; k < 3; k++) begin
                p = 8'(pi);
                m = (k == 0) ? 8'hFF : (k == 1) ? 8'h55 : (p ^ 8'hA3);
                wr(3'd3, 8'hFF);
                wr(3'd2, m);
                wr(3'd4, p);
                chk_reg("R5 status after sw set", 3'd0, p);
                chk_reg("R6 pending", 3'd1, p & m);
                chk_reg("R7 vector", 3'd6, lowest(p & m));
                chk("R6 irq", {7'b0, irq_out}, {7'b0, |(p & m)});
            end
        end
        chk_reg("R2 ack reads zero", 3'd3, 8'h00);
        chk_reg("R2 swset reads zero", 3'd4, 8'h00);
        // R2: read-only writes ignored
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        wr(3'd6, 8'h00);
        chk_reg("R2 status read-only", 3'd0, 8'h00);
        chk_reg("R2 vector read-only", 3'd6, 8'hFF);
        chk_reg("R2 enable kept", 3'd2, (8'hFF ^ 8'hA3));
        // R6: output enable gates irq
        wr(3'd2, 8'hFF);
        wr(3'd4, 8'h10);
        wr(3'd5, 8'h00);
        chk("R6 irq gated", {7'b0, irq_out}, 8'h00);
        chk_reg("R7 vector while gated", 3'd6, 8'h04);
        chk_reg("R2 ctrl readback", 3'd5, 8'h00);
        wr(3'd3, 8'hFF);

        // R5: hardware ignored while software source selected
        wr(3'd5, 8'h01);
        irq_src = 8'h44;
        tick(); tick();
        chk_reg("R5 hw ignored", 3'd0, 8'h00);
        wr(3'd5, 8'h03);
        tick();
        chk_reg("R3 R4 no edge on switch, level seen", 3'd0, 8'h40);
        irq_src = '0;
        wr(3'd3, 8'hFF);
        // R5: software set ignored while hardware selected
        wr(3'd4, 8'h81);
        chk_reg("R5 sw set ignored", 3'd0, 8'h00);

        // R3: edge input
        irq_src[1] = 1'b1;
        tick();
        chk_reg("R3 edge sets", 3'd0, 8'h02);
        chk("R3 irq", {7'b0, irq_out}, 8'h01);
        wr(3'd3, 8'h02);
        chk_reg("R3 ack clears while high", 3'd0, 8'h00);
        tick();
        chk_reg("R3 no reset while held", 3'd0, 8'h00);
        irq_src[1] = 1'b0;
        tick();
        chk_reg("R3 fall no set", 3'd0, 8'h00);
        irq_src[1] = 1'b1;
        tick();
        irq_src[1] = 1'b0;
        tick(); tick();
        chk_reg("R3 sticky after pulse", 3'd0, 8'h02);
        chk_reg("R7 vector edge", 3'd6, 8'h01);
        wr(3'd3, 8'h02);

        // R4: level input
        irq_src[5] = 1'b1;
        tick();
        chk_reg("R4 level sets", 3'd0, 8'h20);
        wr(3'd3, 8'h20);
        chk_reg("R4 ack blocked while high", 3'd0, 8'h20);
        chk_reg("R8 set beats ack", 3'd1, 8'h20);
        irq_src[5] = 1'b0;
        tick();
        chk_reg("R4 held after drop", 3'd0, 8'h20);
        wr(3'd3, 8'h20);
        chk_reg("R4 ack after drop", 3'd0, 8'h00);

        // R8: software set and ack in one cycle is not possible on one port;
        // same-cycle edge and ack instead
        irq_src[2] = 1'b1;
        wr(3'd3, 8'h04);
        chk_reg("R8 edge beats ack", 3'd0, 8'h04);
        irq_src = '0;
        wr(3'd3, 8'hFF);
        chk_reg("R1 clean end", 3'd6, 8'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule